// File: doc/BRIEF.md
# Round-Trip Propagation Delay Estimator

This block measures the one-way radio propagation delay between the local node and a single neighbor. It does this with a series of echo exchanges. The result feeds the timing-correction logic, which later compares arrival times against these stored delays. The block works in one of two roles, chosen when a run starts.

In the measuring role, the block requests a transmission of the timing sequence and restarts a local tick counter in that same cycle. It then waits for the correlator's peak strobe that marks the echo and records the counter value at that strobe. After sixteen good trials it averages the recordings and removes a fixed turnaround latency. It halves what is left and writes the one-way delay into an external per-neighbor delay memory, using the neighbor index given at start. A trial that gets no echo before a programmable limit is sent again and does not count toward the sixteen.

In the echoing role, the block answers every peak strobe with a transmit request in the same cycle. It also restarts its counter, and it finishes after sixteen answers. One counter tick is one correlator clock period (3.2 ns at 312.5 MHz).

Top module: `rtdelay_est`

## Requirements
- R1: In the measuring role, `tx_trig_o` is high for exactly one cycle, in the cycle after `start_i` is accepted in idle. After each counted or timed-out trial it is high again for one cycle, in the cycle after that trial ends.
- R2: The recorded round-trip value of a trial is D, where the peak strobe comes D cycles after the cycle in which `tx_trig_o` was high. A peak strobe in the very cycle where the tick count equals `timeout_i` is still accepted.
- R3: A run counts exactly 16 accepted trials. The mean is the sum of the 16 recorded values shifted right by 4, with the remainder dropped.
- R4: The written delay is (mean − turnaround) shifted right by 1. When the mean is not greater than the turnaround, the written delay is 0. `turnaround_i` is sampled when `start_i` is accepted.
- R5: `wr_en_o` is high for exactly one cycle, in the cycle after the sixteenth accepted peak. `wr_addr_o` then equals the `nbr_i` that was sampled at start.
- R6: If no peak arrives by the cycle in which the tick count equals `timeout_i`, a new transmit request follows in the next cycle, and that trial does not count.
- R7: `done_o` is high for exactly one cycle, in the cycle after the write.
- R8: In the echoing role (`role_i`=1), every peak strobe drives `tx_trig_o` high in the same cycle. After the sixteenth strobe, `done_o` pulses in the next cycle and no write takes place.
- R9: `start_i` is ignored while a run is in progress. A peak strobe is ignored in idle and in a transmit cycle of the measuring role.
- R10: After reset, `tx_trig_o`, `wr_en_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Correlator-rate clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a run (accepted only in idle) |
| role_i | input | 1 | 0 = measuring, 1 = echoing; sampled at start |
| nbr_i | input | NBR_W | Neighbor index; sampled at start |
| peak_i | input | 1 | Correlation peak strobe |
| turnaround_i | input | TIMER_W | Fixed turnaround latency in ticks |
| timeout_i | input | TIMER_W | Echo wait limit in ticks (at least 1) |
| tx_trig_o | output | 1 | Transmit-sequence request |
| wr_en_o | output | 1 | Delay memory write strobe |
| wr_addr_o | output | NBR_W | Delay memory address (neighbor) |
| wr_data_o | output | TIMER_W | One-way delay in ticks |
| done_o | output | 1 | Run finished pulse |

## Verification
The hardest case to reach from the ports is the interplay of a lost echo with the count of good trials. A timeout must restart the trial without adding anything to the sum. It must also leave the sixteen-trial count unchanged, and then the run must still end on the correct cycle. To reach this, the bench acts as the far node: it answers each transmit request with a scripted delay. In chosen trials it withholds the answer for exactly `timeout_i` cycles, and in one trial it answers on the limit cycle itself. Other runs place stray peak and start pulses in transmit and wait cycles. The written delay, the write cycle and the done cycle are then compared with values computed from the script.

// File: rtl/rtd_pkg.sv
package rtd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SEND   = 3'd1,
    ST_WAIT   = 3'd2,
    ST_LISTEN = 3'd3,
    ST_COMMIT = 3'd4,
    ST_DONE   = 3'd5
  } rtd_state_e;

  localparam logic ROLE_MEASURE = 1'b0;
  localparam logic ROLE_ECHO    = 1'b1;
endpackage

// File: rtl/rtd_timer.sv
module rtd_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_i,
  input  logic         run_i,
  output logic [W-1:0] value_o
);
  localparam logic [W-1:0] MAXV = '1;
  localparam logic [W-1:0] ONE  = W'(1);

  // The cycle in which clear_i is high counts as tick 0.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      value_o <= '0;
    else if (clear_i)
      value_o <= ONE;
    else if (run_i && value_o != MAXV)
      value_o <= value_o + ONE;
  end
endmodule

// File: rtl/rtd_accum.sv
module rtd_accum #(
  parameter int W    = 16,
  parameter int LOG2 = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              add_i,
  input  logic [W-1:0]      sample_i,
  output logic [W+LOG2-1:0] sum_o,
  output logic              last_o
);
  localparam int SUM_W = W + LOG2;

  logic [LOG2-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_o <= '0;
      cnt_q <= '0;
    end else if (clear_i) begin
      sum_o <= '0;
      cnt_q <= '0;
    end else if (add_i) begin
      sum_o <= sum_o + SUM_W'(sample_i);
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign last_o = (cnt_q == {LOG2{1'b1}});

  assert_clear_empties_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (sum_o == '0 && !last_o));
endmodule

// File: rtl/rtd_ctrl.sv
module rtd_ctrl
  import rtd_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         role_i,
  input  logic         peak_i,
  input  logic [W-1:0] timer_i,
  input  logic [W-1:0] timeout_i,
  input  logic         last_i,
  output logic         tx_trig_o,
  output logic         timer_clear_o,
  output logic         timer_run_o,
  output logic         acc_clear_o,
  output logic         acc_add_o,
  output logic         wr_en_o,
  output logic         done_o
);
  rtd_state_e st_q, st_d;

  logic expired;
  assign expired = (timer_i >= timeout_i);

  always_comb begin
    st_d          = st_q;
    tx_trig_o     = 1'b0;
    timer_clear_o = 1'b0;
    timer_run_o   = 1'b0;
    acc_clear_o   = 1'b0;
    acc_add_o     = 1'b0;
    wr_en_o       = 1'b0;
    done_o        = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          acc_clear_o = 1'b1;
          st_d = (role_i == ROLE_ECHO) ? ST_LISTEN : ST_SEND;
        end
      end
      ST_SEND: begin
        tx_trig_o     = 1'b1;
        timer_clear_o = 1'b1;
        st_d          = ST_WAIT;
      end
      ST_WAIT: begin
        timer_run_o = 1'b1;
        if (peak_i) begin
          acc_add_o = 1'b1;
          st_d = last_i ? ST_COMMIT : ST_SEND;
        end else if (expired) begin
          st_d = ST_SEND;
        end
      end
      ST_LISTEN: begin
        timer_run_o = 1'b1;
        if (peak_i) begin
          tx_trig_o     = 1'b1;
          timer_clear_o = 1'b1;
          acc_add_o     = 1'b1;
          if (last_i) st_d = ST_DONE;
        end
      end
      ST_COMMIT: begin
        wr_en_o = 1'b1;
        st_d    = ST_DONE;
      end
      ST_DONE: begin
        done_o = 1'b1;
        st_d   = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assert_retry_after_timeout_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && !peak_i && timer_i >= timeout_i) |=> tx_trig_o);
  assert_done_after_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |=> (done_o && !wr_en_o));
  assert_no_trig_in_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_o && tx_trig_o));
endmodule

// File: rtl/rtdelay_est.sv
module rtdelay_est #(
  parameter int TIMER_W    = 16,
  parameter int TRIAL_LOG2 = 4,
  parameter int NBR_W      = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               role_i,
  input  logic [NBR_W-1:0]   nbr_i,
  input  logic               peak_i,
  input  logic [TIMER_W-1:0] turnaround_i,
  input  logic [TIMER_W-1:0] timeout_i,
  output logic               tx_trig_o,
  output logic               wr_en_o,
  output logic [NBR_W-1:0]   wr_addr_o,
  output logic [TIMER_W-1:0] wr_data_o,
  output logic               done_o
);
  localparam int SUM_W = TIMER_W + TRIAL_LOG2;

  // Mean of the trials, less turnaround, halved; clamps at zero.
  function automatic logic [TIMER_W-1:0] one_way(input logic [SUM_W-1:0] sum,
                                                 input logic [TIMER_W-1:0] turn);
    logic [TIMER_W-1:0] mean;
    mean = sum[SUM_W-1:TRIAL_LOG2];
    if (mean > turn) one_way = (mean - turn) >> 1;
    else             one_way = '0;
  endfunction

  // Named internal events
  logic               ev_timer_clear;
  logic               ev_timer_run;
  logic               ev_acc_clear;
  logic               ev_acc_add;
  logic               ev_last;
  logic [TIMER_W-1:0] tick;
  logic [SUM_W-1:0]   sum;
  logic [NBR_W-1:0]   nbr_q;
  logic [TIMER_W-1:0] turn_q;

  rtd_timer #(.W(TIMER_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (ev_timer_clear),
    .run_i   (ev_timer_run),
    .value_o (tick)
  );

  rtd_accum #(.W(TIMER_W), .LOG2(TRIAL_LOG2)) u_accum (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (ev_acc_clear),
    .add_i    (ev_acc_add),
    .sample_i (tick),
    .sum_o    (sum),
    .last_o   (ev_last)
  );

  rtd_ctrl #(.W(TIMER_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .role_i        (role_i),
    .peak_i        (peak_i),
    .timer_i       (tick),
    .timeout_i     (timeout_i),
    .last_i        (ev_last),
    .tx_trig_o     (tx_trig_o),
    .timer_clear_o (ev_timer_clear),
    .timer_run_o   (ev_timer_run),
    .acc_clear_o   (ev_acc_clear),
    .acc_add_o     (ev_acc_add),
    .wr_en_o       (wr_en_o),
    .done_o        (done_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nbr_q  <= '0;
      turn_q <= '0;
    end else if (ev_acc_clear) begin
      nbr_q  <= nbr_i;
      turn_q <= turnaround_i;
    end
  end

  assign wr_addr_o = nbr_q;
  assign wr_data_o = one_way(sum, turn_q);

  assert_timer_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_trig_o |=> (tick == TIMER_W'(1)));
  assert_write_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> $past(ev_acc_add && ev_last));
  assert_addr_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(ev_acc_clear) && wr_en_o) |-> $stable(wr_addr_o));
endmodule

// File: tb/rtdelay_est_bench.sv
module rtdelay_est_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 16;
  localparam int NW = 2;
  localparam int TMO = 30;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic          role_i = 1'b0;
  logic [NW-1:0] nbr_i = '0;
  logic          peak_i = 1'b0;
  logic [TW-1:0] turnaround_i = '0;
  logic [TW-1:0] timeout_i = TW'(TMO);
  logic          tx_trig_o, wr_en_o, done_o;
  logic [NW-1:0] wr_addr_o;
  logic [TW-1:0] wr_data_o;

  int total = 0;
  int bad = 0;
  bit ended = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtdelay_est #(.TIMER_W(TW), .TRIAL_LOG2(4), .NBR_W(NW)) u_rtdelay_est (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .role_i(role_i), .nbr_i(nbr_i),
    .peak_i(peak_i), .turnaround_i(turnaround_i), .timeout_i(timeout_i),
    .tx_trig_o(tx_trig_o), .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o),
    .wr_data_o(wr_data_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive inputs just after the falling edge, then let logic settle.
  task automatic step(input logic pk, input logic st);
    @(negedge clk);
    peak_i = pk;
    start_i = st;
    #1;
  endtask

  function automatic int delay_of(input int r, input int k);
    if (r == 0 && k == 0) return TMO;  // echo exactly on the limit (R2)
    return 2 + ((r * 5 + k * 3) % 23);
  endfunction

  function automatic int expect_oneway(input int sum, input int turn);
    int mean;
    mean = sum / 16;
    if (mean <= turn) return 0;
    return (mean - turn) / 2;
  endfunction

  task automatic run_measure(input int r);
    int sum = 0;
    int turn;
    int d;
    bit lose;
    bit noise;
    turn  = (r % 5 == 4) ? 40 : (r % 5) * 3;
    lose  = (r % 3 == 1);
    noise = (r % 4 == 2);
    role_i = 1'b0;
    nbr_i = NW'(r % 4);
    turnaround_i = TW'(turn);
    step(1'b0, 1'b1);
    step(noise, 1'b0);
    for (int k = 0; k < 16; k++) begin
      chk(tx_trig_o === 1'b1, "R1 trigger", int'(tx_trig_o), 1);
      if (lose && (k == 5 || k == 11)) begin
        for (int j = 1; j <= TMO; j++) step(1'b0, 1'b0);
        chk(tx_trig_o === 1'b0, "R6 no trigger before limit", int'(tx_trig_o), 0);
        step(1'b0, 1'b0);
        chk(tx_trig_o === 1'b1, "R6 retry trigger", int'(tx_trig_o), 1);
      end
      d = delay_of(r, k);
      for (int j = 1; j <= d; j++) begin
        // stray start while busy (R9)
        step(j == d, noise && k == 3 && j == 1);
        if (j < d && tx_trig_o !== 1'b0)
          chk(1'b0, "R9 stray trigger in wait", int'(tx_trig_o), 0);
      end
      sum += d;
      if (k < 15) step(noise, 1'b0);
      else        step(1'b0, 1'b0);
    end
    chk(wr_en_o === 1'b1, "R5 write strobe", int'(wr_en_o), 1);
    chk(wr_addr_o === NW'(r % 4), "R5 write address", int'(wr_addr_o), r % 4);
    chk(int'(wr_data_o) == expect_oneway(sum, turn), "R3 R4 delay value",
        int'(wr_data_o), expect_oneway(sum, turn));
    chk(done_o === 1'b0, "R7 done not with write", int'(done_o), 0);
    step(1'b0, 1'b0);
    chk(done_o === 1'b1 && wr_en_o === 1'b0, "R7 done after write", int'(done_o), 1);
    step(1'b0, 1'b0);
    chk(done_o === 1'b0 && tx_trig_o === 1'b0, "R7 done single cycle", int'(done_o), 0);
  endtask

  task automatic run_echo();
    bit wrote = 1'b0;
    step(1'b1, 1'b0);
    chk(tx_trig_o === 1'b0, "R9 peak ignored in idle", int'(tx_trig_o), 0);
    role_i = 1'b1;
    step(1'b0, 1'b1);
    for (int k = 0; k < 16; k++) begin
      step(1'b0, 1'b0);
      chk(tx_trig_o === 1'b0, "R8 quiet between peaks", int'(tx_trig_o), 0);
      step(1'b1, 1'b0);
      chk(tx_trig_o === 1'b1, "R8 same-cycle echo", int'(tx_trig_o), 1);
      if (wr_en_o) wrote = 1'b1;
    end
    step(1'b0, 1'b0);
    chk(done_o === 1'b1, "R8 done after 16 echoes", int'(done_o), 1);
    chk(!wrote && wr_en_o === 1'b0, "R8 no write in echo role", int'(wrote), 0);
    step(1'b0, 1'b0);
    chk(done_o === 1'b0, "R8 done single cycle", int'(done_o), 0);
    role_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!ended) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(tx_trig_o === 1'b0 && wr_en_o === 1'b0 && done_o === 1'b0,
        "R10 reset outputs", int'(tx_trig_o) + int'(wr_en_o) + int'(done_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 1'b0);
    chk(tx_trig_o === 1'b0, "R10 idle after reset", int'(tx_trig_o), 0);
    for (int r = 0; r < 12; r++) begin
      run_measure(r);
      repeat (2) step(1'b0, 1'b0);
    end
    run_echo();
    run_measure(7);
    ended = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule